// File: doc/BRIEF.md
# Display Contrast PWM Generator

This block drives a single pulse-width-modulated pin whose average level, once smoothed by an external RC network, sets the contrast voltage of a display panel. An 8-bit free-running step counter advances only on enable pulses from a power-of-two prescaler. Each step the counter is compared with a programmed threshold, and a polarity bit chooses whether the pin is high or low while the counter is below that threshold.

Software reaches the block through one 32-bit configuration word on a small synchronous bus (word address, write strobe, write data, registered read data). The threshold and polarity take effect at the next counter wrap, so a change never produces a truncated or doubled pulse. Any write to the word restarts the prescaler phase so that a new division ratio begins from a clean boundary.

Top module: `contrast_pwm`

## Requirements
- R1: The configuration word holds the threshold in bits 15:8, the polarity bit in bit 4 and the 3-bit rate code in bits 2:0; all other bits read back as zero (writing 0xFFFFFFFF reads back 0x0000FF17).
- R2: After reset the configuration word reads zero, the counter is at zero and pwm_out is high.
- R3: With polarity 1, pwm_out is high for exactly the counter steps whose value is below the threshold and low for the rest.
- R4: With polarity 0, pwm_out is the inverse of the polarity-1 waveform (low below the threshold, high otherwise).
- R5: Rate codes 0 to 6 make the counter advance once every 1, 2, 4, 8, 16, 32 or 64 clocks respectively.
- R6: Rate code 7 behaves exactly like code 6 (one step per 64 clocks).
- R7: The counter is 8 bits and wraps from 255 to 0, so one output period lasts 256 steps.
- R8: A threshold of 0 keeps the output at its inactive level for the whole period; a threshold of 255 keeps it active for 255 of the 256 steps.
- R9: A new threshold or polarity is taken into use only when the counter wraps to 0; the period in progress finishes with the old values.
- R10: Every write to the configuration word restarts the prescaler phase, so the next counter step comes one full division interval after the write.
- R11: Read data appears one clock after the address is presented; addresses other than word 0 read as zero and writes to them are ignored.
- R12: pwm_out is registered: it reflects the counter value and active settings one clock after the counter holds them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the source of the prescaler |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | ADDR_W | Word address of the access |
| cfg_we | input | 1 | Write strobe, one clock per write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for the address of the previous clock |
| pwm_out | output | 1 | Contrast PWM pin |

## Verification
Read data is due on the clock after the address is sampled, a write changes the prescaler phase on the edge that samples it, and the pin follows the counter one clock later; a new threshold or polarity shows only in the period after the next wrap, which may be up to 256 times the division interval away. A behavioural model in the bench advances with the same edges and is compared with both outputs at every falling edge, so each result is checked in exactly the cycle it is due. Directed runs measure pulse lengths, periods and duty counts only after waiting past the wrap that makes the new settings active, and the restart check issues its write in the cycle right after a rising edge so the expected stretch of the pulse is a fixed number of clocks.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int DATA_W  = 32;
  localparam int CMP_W   = 8;
  localparam int SEL_W   = 3;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;
  localparam int SEL_LSB = 0;

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic             pol;
    logic [SEL_W-1:0] sel;
  } cfg_t;

  function automatic logic [DATA_W-1:0] pack_cfg(input cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CMP_LSB +: CMP_W] = c.cmp;
    w[POL_BIT]          = c.pol;
    w[SEL_LSB +: SEL_W] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CFG_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg,
  output logic              cfg_wr
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFFSET);

  logic hit;
  logic unused_wbits;

  assign hit    = (addr == CFG_ADDR);
  assign cfg_wr = hit && we;
  assign unused_wbits = ^{wdata[DATA_W-1:CMP_LSB+CMP_W],
                          wdata[CMP_LSB-1:POL_BIT+1],
                          wdata[POL_BIT-1:SEL_LSB+SEL_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      rdata <= '0;
    end else begin
      if (cfg_wr) begin
        cfg.cmp <= wdata[CMP_LSB +: CMP_W];
        cfg.pol <= wdata[POL_BIT];
        cfg.sel <= wdata[SEL_LSB +: SEL_W];
      end
      rdata <= hit ? pack_cfg(cfg) : '0;
    end
  end

  // R1: a write lands each field from its own bit positions
  assert_field_capture_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (cfg.cmp == $past(wdata[CMP_LSB +: CMP_W])) &&
               (cfg.pol == $past(wdata[POL_BIT])) &&
               (cfg.sel == $past(wdata[SEL_LSB +: SEL_W])));

  // R11: an access elsewhere leaves the word untouched
  assert_foreign_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> $stable(cfg));
endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler
  import cpwm_pkg::*;
#(
  parameter int MAX_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             tick
);
  localparam int PH_W = MAX_LOG2;

  logic [SEL_W-1:0] eff;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  mask;

  assign eff = (int'(sel) > MAX_LOG2) ? SEL_W'(MAX_LOG2) : sel;

  for (genvar gi = 0; gi < PH_W; gi++) begin : g_mask
    assign mask[gi] = (int'(eff) > gi);
  end

  assign tick = ((phase & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  // R5: code 0 steps the counter on every clock
  assert_full_rate_R5: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> tick);

  // R10: after a write the phase starts over, so only divide-by-1 ticks at once
  assert_phase_restart_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tick == (sel == '0)));
endmodule

// File: rtl/cpwm_core.sv
module cpwm_core
  import cpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CMP_W-1:0] cfg_cmp,
  input  logic             cfg_pol,
  output logic             pwm_out
);
  localparam logic [CMP_W-1:0] CNT_MAX = '1;

  logic [CMP_W-1:0] cnt;
  logic [CMP_W-1:0] cmp_sh;
  logic             pol_sh;
  logic             below;
  logic             wrap;

  assign wrap  = tick && (cnt == CNT_MAX);
  assign below = (cnt < cmp_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cmp_sh  <= '0;
      pol_sh  <= 1'b0;
      pwm_out <= 1'b1;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (wrap) begin
        cmp_sh <= cfg_cmp;
        pol_sh <= cfg_pol;
      end
      pwm_out <= pol_sh ? below : ~below;
    end
  end

  // R7: counter moves by one (mod 256) on an enable and holds otherwise
  assert_step_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt + 1'b1)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R9: active settings change only at the wrap
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(cmp_sh) && $stable(pol_sh)));

  // R8: a zero threshold keeps the pin inactive
  assert_zero_inactive_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_sh == '0) |=> (pwm_out == !$past(pol_sh)));

  // R3: polarity 1 drives high below the threshold
  assert_active_high_R3: assert property (@(posedge clk) disable iff (rst)
    (pol_sh && (cnt < cmp_sh)) |=> pwm_out);
endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm
  import cpwm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CFG_OFFSET = 0,
  parameter int MAX_LOG2   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              pwm_out
);
  cfg_t cfg;
  logic cfg_wr;
  logic tick;

  cpwm_regs #(
    .ADDR_W    (ADDR_W),
    .CFG_OFFSET(CFG_OFFSET)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (cfg_addr),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg),
    .cfg_wr(cfg_wr)
  );

  cpwm_prescaler #(
    .MAX_LOG2(MAX_LOG2)
  ) u_presc (
    .clk    (clk),
    .rst    (rst),
    .sel    (cfg.sel),
    .restart(cfg_wr),
    .tick   (tick)
  );

  cpwm_core u_core (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cfg_cmp(cfg.cmp),
    .cfg_pol(cfg.pol),
    .pwm_out(pwm_out)
  );
endmodule

// File: tb/sim_contrast_pwm.sv
module sim_contrast_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              pwm;

  int vectors = 0;
  int fails   = 0;

  contrast_pwm #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .cfg_addr(addr), .cfg_we(we),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .pwm_out(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [7:0]  m_cmp;
  logic        m_pol;
  logic [2:0]  m_ps;
  int          m_phase, m_cnt, m_scmp;
  logic        m_spol, m_out;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    int div;
    bit tk, hit;
    if (rst) begin
      m_cmp = 0; m_pol = 0; m_ps = 0; m_phase = 0; m_cnt = 0;
      m_scmp = 0; m_spol = 0; m_out = 1; m_rdata = 0;
    end else begin
      div = 1 << ((m_ps > 3'd6) ? 6 : int'(m_ps));
      tk  = ((m_phase % div) == div - 1);
      hit = we && (addr == 0);
      m_rdata = (addr == 0) ? {16'h0, m_cmp, 3'b000, m_pol, 1'b0, m_ps} : 32'h0;
      m_out = m_spol ? (m_cnt < m_scmp) : !(m_cnt < m_scmp);
      if (tk) begin
        if (m_cnt == 255) begin
          m_scmp = int'(m_cmp); m_spol = m_pol; m_cnt = 0;
        end else m_cnt = m_cnt + 1;
      end
      m_phase = hit ? 0 : m_phase + 1;
      if (hit) begin
        m_cmp = wdata[15:8]; m_pol = wdata[4]; m_ps = wdata[2:0];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL R11 cfg_rdata: actual %h expected %h", rdata, m_rdata);
      end
      vectors++;
      if (pwm !== m_out) begin
        fails++;
        $display("FAIL R12 pwm_out at %0t: actual %b expected %b", $time, pwm, m_out);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
    addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    while (pwm !== 1'b0) @(negedge clk);
    while (pwm !== 1'b1) @(negedge clk);
  endtask

  task automatic run_len(output int n);
    wait_rise();
    n = 0;
    while (pwm === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic period_len(output int n);
    wait_rise();
    n = 0;
    while (pwm === 1'b1) begin n++; @(negedge clk); end
    while (pwm === 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic duty(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm === 1'b1) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    chk(pwm === 1'b1, "R2 pwm after reset", pwm, 1);
    rd(0, v);
    chk(v == 32'h0, "R2 word after reset", v, 0);

    // R1: field placement, reserved bits zero
    wr(0, 32'hFFFF_FFFF);
    rd(0, v);
    chk(v == 32'h0000_FF17, "R1 readback", v, 32'h0000_FF17);

    // R11: other address
    wr(1, 32'h0000_1234);
    rd(0, v);
    chk(v == 32'h0000_FF17, "R11 foreign write ignored", v, 32'h0000_FF17);
    rd(1, v);
    chk(v == 32'h0, "R11 foreign read zero", v, 0);

    // R3 / R4: polarity
    wr(0, 32'h0000_4010); idle(600); duty(n);
    chk(n == 64, "R3 polarity 1 high steps", n, 64);
    wr(0, 32'h0000_4000); idle(600); duty(n);
    chk(n == 192, "R4 polarity 0 high steps", n, 192);

    // R8: threshold extremes
    wr(0, 32'h0000_0010); idle(600); duty(n);
    chk(n == 0, "R8 threshold 0", n, 0);
    wr(0, 32'h0000_FF10); idle(600); duty(n);
    chk(n == 255, "R8 threshold 255", n, 255);

    // R9: change mid-period
    wr(0, 32'h0000_8010); idle(600);
    wait_rise();
    n = 1;
    wr(0, 32'h0000_2010);
    while (pwm === 1'b1) begin n++; @(negedge clk); end
    chk(n == 128, "R9 running pulse keeps old threshold", n, 128);
    run_len(n);
    chk(n == 32, "R9 new threshold after wrap", n, 32);

    // R5 / R10: divide by 8, then restart by rewrite
    wr(0, 32'h0000_0113); idle(2200);
    run_len(n);
    chk(n == 8, "R5 divide-by-8 step", n, 8);
    wait_rise();
    n = 1;
    wr(0, 32'h0000_0113);
    while (pwm === 1'b1) begin n++; @(negedge clk); end
    chk(n == 10, "R10 rewrite restarts phase", n, 10);

    // R5 / R7: divide by 4
    wr(0, 32'h0000_8012); idle(1100);
    run_len(n);
    chk(n == 512, "R5 divide-by-4 pulse", n, 512);
    period_len(n);
    chk(n == 1024, "R7 period 256 steps", n, 1024);

    // R5 / R6: slowest rates
    wr(0, 32'h0000_8016);
    run_len(n);
    chk(n == 8192, "R5 divide-by-64 pulse", n, 8192);
    wr(0, 32'h0000_8017);
    run_len(n);
    chk(n == 8192, "R6 code 7 equals divide-by-64", n, 8192);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule